// File: doc/BRIEF.md
# CAN Fault-Confinement State and Interrupt Controller

This block watches the transmit and receive error counters of a CAN node and turns their threshold crossings, together with bus-off and bus-error events, into sticky status and interrupt flags. It also collects per-mailbox interrupt requests and routes every flagged event to one of two interrupt lines. How the counters increment and how the protocol is decoded are outside this block. Counters and event pulses come from the protocol engine, and a small configuration write port comes from the host.

Two counter thresholds are applied: an early-warning level (either counter at or above 96) and an error-passive level (either counter at or above 128). Each flag is raised on the cycle in which its condition starts, not on every cycle in which it holds. A bus-off pulse raises the bus-off flag. A bus-error pulse records its cause bits. The three fault flags together are called system interrupts. They appear in whichever of the two flag registers the routing bit selects. Each mailbox has a mask bit and a line-select bit. For each line, the flag register shows a summary mailbox bit and the number of the highest-numbered enabled mailbox that is pending on that line.

Top module: `can_fault_irq`

Configuration addresses on `cfg_addr`:

| Address | Name | Access | Effect |
|---|---|---|---|
| 0 | status | write 1 to clear | clears the matching bits of `err_status` |
| 1 | line-0 flags | write 1 to clear | clears fault flags shown in `flags0` |
| 2 | line-1 flags | write 1 to clear | clears fault flags shown in `flags1` |
| 3 | global mask | write | stores bits 0, 1, 2, 8, 9 and 10 |
| 4 | mailbox mask | write | one enable bit per mailbox |
| 5 | mailbox line select | write | 0 selects line 0, 1 selects line 1 |
| 6 | mailbox acknowledge | write 1 to clear | clears pending mailbox bits |

## Requirements
- R1: When either counter first becomes 96 or more, `err_status` bit 16 and fault flag bit 8 are set one cycle later. They stay set while the condition holds, and after the counters fall below 96 they stay set until cleared. A new rise sets them again.
- R2: When either counter first becomes 128 or more, `err_status` bit 17 and fault flag bit 9 are set one cycle later. These bits are also set only on the rising transition.
- R3: A `busoff_evt` pulse sets `err_status` bit 18 and fault flag bit 10 one cycle later.
- R4: A `berr_evt` pulse copies `berr_cause` into `err_status` bits 24:19 as an OR with the bits already set. The cause order is ack (0), stuff (1), CRC (2), stuck-dominant (3), bit (4), form (5). Cause bits are ignored when no pulse is present.
- R5: A write to address 0 clears each `err_status` bit written as 1 and leaves the others unchanged. Only bits 24:16 exist. If a set and a clear fall in the same cycle, the set wins.
- R6: A `mbx_req` bit marks that mailbox pending until a 1 is written to its bit at address 6. A request in the same cycle as the acknowledge wins. A pending mailbox whose mask bit is 1 shows in the flag register of the line its select bit names: bit 15 is set and bits 4:0 hold the highest-numbered such mailbox. Bits 4:0 are 0 when no mailbox is shown.
- R7: The three fault flags (bits 10:8) appear in `flags0` when global mask bit 2 is 0 and in `flags1` when it is 1. They read as 0 in the other register.
- R8: `irq0` is 1 exactly when, one cycle earlier, global mask bit 0 was set and `flags0` had a shown mailbox or a fault flag whose enable bit was set. The enable bits are global mask bits 8, 9 and 10, for flags 8, 9 and 10. `irq1` follows the same rule with mask bit 1 and `flags1`.
- R9: A write to address 1 or 2 clears the fault flags written as 1, but only in the register where they are currently shown. Bit 15 and bits 4:0 cannot be written. If a set and a clear fall in the same cycle, the set wins.
- R10: After reset, all status, flags, masks and pending bits are 0 and both lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| tec | input | CNT_W | transmit error counter |
| rec | input | CNT_W | receive error counter |
| busoff_evt | input | 1 | bus-off entry pulse |
| berr_evt | input | 1 | bus-error event pulse |
| berr_cause | input | 6 | cause bits qualifying `berr_evt` |
| mbx_req | input | NMBX | per-mailbox interrupt request pulses |
| cfg_we | input | 1 | configuration write strobe |
| cfg_addr | input | 3 | configuration address |
| cfg_wdata | input | 32 | configuration write data |
| irq0 | output | 1 | interrupt line 0 |
| irq1 | output | 1 | interrupt line 1 |
| err_status | output | 32 | sticky error status |
| flags0 | output | 32 | flags routed to line 0 |
| flags1 | output | 32 | flags routed to line 1 |

## Verification
The critical coincidence is an event arriving in the same cycle as a write-1-to-clear of the flag it sets. Examples are a bus-off pulse during a status clear, a counter crossing during a flag clear, and a mailbox request during its own acknowledge. The bench creates each of these by driving the event and the clear write on the same clock edge. It then expects the bit to remain set in the next cycle. A cycle model built from the requirements is compared against every output on every cycle. This covers sweeps of both counters through all 256 values, all 64 cause patterns, every single mailbox on both lines, and all combinations of the line enables.

// File: rtl/can_fault_pkg.sv
package can_fault_pkg;
  localparam int ST_WARN  = 16;
  localparam int ST_PASS  = 17;
  localparam int ST_BOFF  = 18;
  localparam int ST_CAUSE = 19;
  localparam int CAUSE_W  = 6;
  localparam logic [31:0] ST_MASK = 32'h01FF_0000;

  localparam int FL_SYS   = 8;
  localparam int FL_MBX   = 15;
  localparam int SYS_W    = 3;

  localparam int GM_L0    = 0;
  localparam int GM_L1    = 1;
  localparam int GM_ROUTE = 2;
  localparam logic [31:0] GM_MASK = 32'h0000_0707;

  typedef enum logic [2:0] {
    A_STATUS = 3'd0,
    A_FLAG0  = 3'd1,
    A_FLAG1  = 3'd2,
    A_GMASK  = 3'd3,
    A_MMASK  = 3'd4,
    A_MLINE  = 3'd5,
    A_MACK   = 3'd6
  } cfg_addr_e;
endpackage

// File: rtl/can_fault_level.sv
module can_fault_level #(
  parameter int CNT_W    = 8,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] tec,
  input  logic [CNT_W-1:0] rec,
  output logic             warn_rise,
  output logic             pass_rise
);
  localparam logic [CNT_W-1:0] WLIM = CNT_W'(WARN_LIM);
  localparam logic [CNT_W-1:0] PLIM = CNT_W'(PASS_LIM);

  logic warn_now, pass_now, warn_q, pass_q;

  assign warn_now = (tec >= WLIM) || (rec >= WLIM);
  assign pass_now = (tec >= PLIM) || (rec >= PLIM);

  always_ff @(posedge clk) begin
    if (rst) begin
      warn_q <= 1'b0;
      pass_q <= 1'b0;
    end else begin
      warn_q <= warn_now;
      pass_q <= pass_now;
    end
  end

  assign warn_rise = warn_now && !warn_q;
  assign pass_rise = pass_now && !pass_q;
endmodule

// File: rtl/can_fault_status.sv
module can_fault_status
  import can_fault_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               warn_rise,
  input  logic               pass_rise,
  input  logic               busoff_evt,
  input  logic               berr_evt,
  input  logic [CAUSE_W-1:0] berr_cause,
  input  logic [31:0]        clr_mask,
  output logic [31:0]        status
);
  logic [31:0] set_vec;

  always_comb begin
    set_vec = '0;
    set_vec[ST_WARN] = warn_rise;
    set_vec[ST_PASS] = pass_rise;
    set_vec[ST_BOFF] = busoff_evt;
    if (berr_evt) set_vec[ST_CAUSE +: CAUSE_W] = berr_cause;
  end

  always_ff @(posedge clk) begin
    if (rst) status <= '0;
    else     status <= ((status & ~clr_mask) | set_vec) & ST_MASK;
  end
endmodule

// File: rtl/can_fault_mbx.sv
module can_fault_mbx #(
  parameter int NMBX = 32,
  parameter int NUM_W = 5
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NMBX-1:0]       req,
  input  logic [NMBX-1:0]       ack,
  input  logic [NMBX-1:0]       mask,
  input  logic [NMBX-1:0]       line_sel,
  output logic [1:0]            hit,
  output logic [1:0][NUM_W-1:0] num
);
  logic [NMBX-1:0] pend;

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~ack) | req;
  end

  for (genvar l = 0; l < 2; l++) begin : g_line
    logic [NMBX-1:0] vis;
    logic [NUM_W-1:0] top;
    assign vis = pend & mask & ((l == 1) ? line_sel : ~line_sel);
    always_comb begin
      top = '0;
      for (int i = 0; i < NMBX; i++)
        if (vis[i]) top = NUM_W'(i);
    end
    assign hit[l] = |vis;
    assign num[l] = top;
  end
endmodule

// File: rtl/can_fault_irq.sv
module can_fault_irq
  import can_fault_pkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int NMBX     = 32,
  parameter int WARN_LIM = 96,
  parameter int PASS_LIM = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   tec,
  input  logic [CNT_W-1:0]   rec,
  input  logic               busoff_evt,
  input  logic               berr_evt,
  input  logic [5:0]         berr_cause,
  input  logic [NMBX-1:0]    mbx_req,
  input  logic               cfg_we,
  input  logic [2:0]         cfg_addr,
  input  logic [31:0]        cfg_wdata,
  output logic               irq0,
  output logic               irq1,
  output logic [31:0]        err_status,
  output logic [31:0]        flags0,
  output logic [31:0]        flags1
);
  localparam int NUM_W = (NMBX > 1) ? $clog2(NMBX) : 1;

  logic warn_rise, pass_rise;
  logic [31:0] gmask;
  logic [NMBX-1:0] mmask, mline, mack;
  logic [SYS_W-1:0] sys_q, sys_set, sys_clr;
  logic [1:0] mhit;
  logic [1:0][NUM_W-1:0] mnum;
  logic [1:0] line_req;
  logic [1:0][31:0] view;
  logic [31:0] st_clr;

  can_fault_level #(.CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASS_LIM(PASS_LIM)) u_level (
    .clk(clk), .rst(rst), .tec(tec), .rec(rec),
    .warn_rise(warn_rise), .pass_rise(pass_rise)
  );

  assign st_clr = (cfg_we && cfg_addr == A_STATUS) ? cfg_wdata : '0;

  can_fault_status u_status (
    .clk(clk), .rst(rst), .warn_rise(warn_rise), .pass_rise(pass_rise),
    .busoff_evt(busoff_evt), .berr_evt(berr_evt), .berr_cause(berr_cause),
    .clr_mask(st_clr), .status(err_status)
  );

  assign mack = (cfg_we && cfg_addr == A_MACK) ? cfg_wdata[NMBX-1:0] : '0;

  can_fault_mbx #(.NMBX(NMBX), .NUM_W(NUM_W)) u_mbx (
    .clk(clk), .rst(rst), .req(mbx_req), .ack(mack),
    .mask(mmask), .line_sel(mline), .hit(mhit), .num(mnum)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gmask <= '0;
      mmask <= '0;
      mline <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == A_GMASK) gmask <= cfg_wdata & GM_MASK;
      if (cfg_addr == A_MMASK) mmask <= cfg_wdata[NMBX-1:0];
      if (cfg_addr == A_MLINE) mline <= cfg_wdata[NMBX-1:0];
    end
  end

  assign sys_set = {busoff_evt, pass_rise, warn_rise};

  always_comb begin
    sys_clr = '0;
    if (cfg_we && ((cfg_addr == A_FLAG0 && !gmask[GM_ROUTE]) ||
                   (cfg_addr == A_FLAG1 &&  gmask[GM_ROUTE])))
      sys_clr = cfg_wdata[FL_SYS +: SYS_W];
  end

  always_ff @(posedge clk) begin
    if (rst) sys_q <= '0;
    else     sys_q <= (sys_q & ~sys_clr) | sys_set;
  end

  for (genvar l = 0; l < 2; l++) begin : g_view
    logic owns_sys;
    assign owns_sys = (gmask[GM_ROUTE] == (l == 1));
    always_comb begin
      view[l] = '0;
      if (owns_sys) view[l][FL_SYS +: SYS_W] = sys_q;
      view[l][FL_MBX] = mhit[l];
      view[l][NUM_W-1:0] = mnum[l];
    end
    assign line_req[l] = gmask[l] &&
      ((owns_sys && |(sys_q & gmask[FL_SYS +: SYS_W])) || mhit[l]);
  end

  assign flags0 = view[0];
  assign flags1 = view[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq0 <= 1'b0;
      irq1 <= 1'b0;
    end else begin
      irq0 <= line_req[0];
      irq1 <= line_req[1];
    end
  end
endmodule

// File: rtl/can_fault_irq_chk.sv
module can_fault_irq_chk #(
  parameter int CNT_W = 8,
  parameter int NMBX  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] tec,
  input logic [CNT_W-1:0] rec,
  input logic             busoff_evt,
  input logic             berr_evt,
  input logic [5:0]       berr_cause,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic [31:0]      cfg_wdata,
  input logic             irq0,
  input logic             irq1,
  input logic [31:0]      err_status,
  input logic [31:0]      flags0,
  input logic [31:0]      flags1
);
  logic warn_c;
  assign warn_c = (tec >= CNT_W'(96)) || (rec >= CNT_W'(96));

  p_warn_set_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_c) |=> err_status[16]);

  p_busoff_set_r3: assert property (@(posedge clk) disable iff (rst)
    busoff_evt |=> err_status[18] && (flags0[10] || flags1[10]));

  p_cause_set_r4: assert property (@(posedge clk) disable iff (rst)
    berr_evt |=> ((err_status[24:19] & $past(berr_cause)) == $past(berr_cause)));

  p_status_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == 3'd0 && cfg_wdata[18] && !busoff_evt) |=> !err_status[18]);

  p_sys_single_view_r7: assert property (@(posedge clk) disable iff (rst)
    (flags0[10:8] != 3'd0) |-> (flags1[10:8] == 3'd0));

  p_line0_cause_r8: assert property (@(posedge clk) disable iff (rst)
    irq0 |-> $past(flags0 != 32'd0));

  p_line1_cause_r8: assert property (@(posedge clk) disable iff (rst)
    irq1 |-> $past(flags1 != 32'd0));
endmodule

bind can_fault_irq can_fault_irq_chk #(.CNT_W(CNT_W), .NMBX(NMBX)) u_chk (
  .clk(clk), .rst(rst), .tec(tec), .rec(rec), .busoff_evt(busoff_evt),
  .berr_evt(berr_evt), .berr_cause(berr_cause), .cfg_we(cfg_we),
  .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .irq0(irq0), .irq1(irq1),
  .err_status(err_status), .flags0(flags0), .flags1(flags1)
);

// File: tb/test_can_fault_irq.sv
module test_can_fault_irq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] tec = '0, rec = '0;
  logic busoff_evt = 1'b0, berr_evt = 1'b0;
  logic [5:0] berr_cause = '0;
  logic [31:0] mbx_req = '0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic irq0, irq1;
  logic [31:0] err_status, flags0, flags1;

  int checks = 0, failures = 0;

  logic [31:0] m_status, m_pend, m_gim, m_mim, m_mil;
  logic [2:0] m_sys;
  logic m_pw, m_pp, m_irq0, m_irq1;

  always #5 clk = ~clk;

  can_fault_irq i_can_fault_irq (
    .clk(clk), .rst(rst), .tec(tec), .rec(rec), .busoff_evt(busoff_evt),
    .berr_evt(berr_evt), .berr_cause(berr_cause), .mbx_req(mbx_req),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .irq0(irq0), .irq1(irq1), .err_status(err_status),
    .flags0(flags0), .flags1(flags1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_view(input int l);
    logic [31:0] v, vis;
    vis = m_pend & m_mim & ((l == 1) ? m_mil : ~m_mil);
    v = '0;
    if (int'(m_gim[2]) == l) v[10:8] = m_sys;
    v[15] = |vis;
    for (int i = 0; i < 32; i++) if (vis[i]) v[4:0] = 5'(i);
    return v;
  endfunction

  function automatic logic exp_line(input int l);
    logic [31:0] vis;
    vis = m_pend & m_mim & ((l == 1) ? m_mil : ~m_mil);
    return m_gim[l] && (((int'(m_gim[2]) == l) && |(m_sys & m_gim[10:8])) || |vis);
  endfunction

  task automatic model_reset();
    m_status = '0; m_pend = '0; m_gim = '0; m_mim = '0; m_mil = '0;
    m_sys = '0; m_pw = 0; m_pp = 0; m_irq0 = 0; m_irq1 = 0;
  endtask

  // One clock: inputs already driven; update model at the edge, compare after.
  task automatic step(input string tag);
    logic w, p, rw, rp, n0, n1;
    logic [31:0] set_v, clr_v;
    logic [2:0] sclr;
    @(posedge clk);
    w = (tec >= 96) || (rec >= 96);
    p = (tec >= 128) || (rec >= 128);
    rw = w && !m_pw; rp = p && !m_pp;
    n0 = exp_line(0); n1 = exp_line(1);
    set_v = '0;
    set_v[16] = rw; set_v[17] = rp; set_v[18] = busoff_evt;
    if (berr_evt) set_v[24:19] = berr_cause;
    clr_v = (cfg_we && cfg_addr == 3'd0) ? cfg_wdata : '0;
    m_status = ((m_status & ~clr_v) | set_v) & 32'h01FF_0000;
    sclr = (cfg_we && ((cfg_addr == 3'd1 && !m_gim[2]) || (cfg_addr == 3'd2 && m_gim[2])))
           ? cfg_wdata[10:8] : 3'd0;
    m_sys = (m_sys & ~sclr) | {busoff_evt, rp, rw};
    m_pend = (m_pend & ~((cfg_we && cfg_addr == 3'd6) ? cfg_wdata : 32'd0)) | mbx_req;
    if (cfg_we && cfg_addr == 3'd3) m_gim = cfg_wdata & 32'h0000_0707;
    if (cfg_we && cfg_addr == 3'd4) m_mim = cfg_wdata;
    if (cfg_we && cfg_addr == 3'd5) m_mil = cfg_wdata;
    m_pw = w; m_pp = p; m_irq0 = n0; m_irq1 = n1;
    @(negedge clk);
    chk({tag, " status"}, err_status, m_status);
    chk({tag, " flags0"}, flags0, exp_view(0));
    chk({tag, " flags1"}, flags1, exp_view(1));
    chk({tag, " irq0"}, {31'd0, irq0}, {31'd0, m_irq0});
    chk({tag, " irq1"}, {31'd0, irq1}, {31'd0, m_irq1});
    busoff_evt = 0; berr_evt = 0; berr_cause = '0; mbx_req = '0;
    cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string tag);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10: reset state
    chk("R10 status", err_status, 0);
    chk("R10 flags0", flags0, 0);
    chk("R10 flags1", flags1, 0);
    chk("R10 irqs", {30'd0, irq1, irq0}, 0);

    wr(3'd3, 32'h0000_0703, "R8 enable lines");
    // R1 R2: sweep transmit counter, then receive counter
    for (int v = 0; v < 256; v++) begin tec = 8'(v); step("R1 R2 tec sweep"); end
    tec = 0; step("R1 R2 drop");
    wr(3'd0, 32'hFFFF_FFFF, "R5 clear status");
    wr(3'd1, 32'h0000_0700, "R9 clear flags0");
    for (int v = 0; v < 256; v++) begin rec = 8'(v); step("R1 R2 rec sweep"); end
    // R1: falling and rising again re-arms
    rec = 50; step("R1 fall");
    rec = 100; step("R1 rise again");
    tec = 130; step("R2 passive via other counter");
    rec = 0; tec = 0; step("R1 clear counters");

    // R3 and R5: bus-off pulse with coinciding status clear, set wins
    busoff_evt = 1; step("R3 busoff");
    busoff_evt = 1; cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = 32'h0004_0000;
    step("R5 set beats clear");
    wr(3'd0, 32'h0004_0000, "R5 clear busoff");
    wr(3'd0, 32'h0000_0000, "R5 zero write no effect");

    // R4: all cause patterns, with and without the pulse
    for (int c = 0; c < 64; c++) begin
      berr_cause = 6'(c); berr_evt = 1; step("R4 cause");
      berr_cause = 6'(63 - c); step("R4 cause ignored without pulse");
      wr(3'd0, 32'h01F8_0000, "R5 clear causes");
    end

    // R7 R9: route system flags to line 1
    wr(3'd3, 32'h0000_0707, "R7 route to line1");
    busoff_evt = 1; step("R7 busoff on line1");
    wr(3'd1, 32'h0000_0400, "R9 clear wrong register ignored");
    busoff_evt = 1; cfg_we = 1; cfg_addr = 3'd2; cfg_wdata = 32'h0000_0400;
    step("R9 set beats clear");
    wr(3'd2, 32'h0000_0700, "R9 clear line1");
    tec = 200; cfg_we = 1; cfg_addr = 3'd2; cfg_wdata = 32'h0000_0300;
    step("R9 rise beats clear");
    wr(3'd3, 32'h0000_0703, "R7 route back to line0");
    tec = 0; step("R7 view line0");

    // R8: every combination of line enables and system enables
    for (int g = 0; g < 64; g++) begin
      wr(3'd3, {21'd0, 3'(g >> 3), 5'd0, 3'(g)}, "R8 mask combo");
      step("R8 line follows");
    end
    wr(3'd1, 32'h0000_0700, "R9 clear all line0");
    wr(3'd2, 32'h0000_0700, "R9 clear all line1");
    wr(3'd3, 32'h0000_0003, "R8 lines only");

    // R6: each mailbox alone on both lines
    wr(3'd4, 32'hFFFF_FFFF, "R6 enable mailboxes");
    for (int i = 0; i < 32; i++) begin
      wr(3'd5, (i % 2 == 1) ? 32'hFFFF_FFFF : 32'h0, "R6 line select");
      mbx_req = 32'd1 << i; step("R6 single mailbox");
      step("R8 line for mailbox");
      wr(3'd6, 32'd1 << i, "R6 ack");
    end
    // R6: multiple pending, highest wins per line; masking; ack coincidence
    wr(3'd5, 32'hAAAA_AAAA, "R6 odd to line1");
    for (int k = 0; k < 40; k++) begin
      mbx_req = 32'h9E37_79B9 * 32'(k + 1) ^ (32'hDEAD_BEEF >> (k % 7));
      step("R6 multi pending");
      wr(3'd4, 32'h9E37_79B9 ^ 32'(k * 977), "R6 mask change");
      mbx_req = 32'h8000_0001; cfg_we = 1; cfg_addr = 3'd6;
      cfg_wdata = 32'hFFFF_0000 | 32'(k);
      step("R6 request beats ack");
    end
    wr(3'd6, 32'hFFFF_FFFF, "R6 ack all");
    step("R8 lines drop");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule